// File: doc/BRIEF.md
# Start Trigger Unit

This block holds a downstream task back until a chosen start condition has been seen. Software or a sequencer picks one of three conditions. The first is a rising edge on one selected digital line. The second is a masked comparison of the digital lines against a pattern. The third is an unsigned comparison of an analog sample code against a threshold. It then pulses `arm`.

While the unit is armed it tests the chosen condition on every clock. On the first hit it emits a single-cycle `start_pulse` and raises a `triggered` flag. The flag stays set until `clear` is pulsed. Digital lines are treated as asynchronous and pass through a synchronizer before any test. The analog sample arrives already in the clock domain, together with a valid strobe.

The unit is a gate in front of the task. It produces no samples and does not run the task.

Top module: `start_trigger_unit`

## Requirements
- R1: While `rst_n` is low, `armed`, `triggered` and `start_pulse` are all low.
- R2: A one-cycle `arm` pulse while the unit is idle (neither armed nor triggered) sets `armed` at the next clock. If `clear` is high in the same cycle, `clear` wins and the unit stays idle.
- R3: With `mode` = 0 (edge), the unit fires on a low-to-high transition of line `din[edge_sel]` after the two-flop synchronizer. `start_pulse` appears on the third rising clock after the line changes. A line that is already high when armed does not fire, and the other lines have no effect.
- R4: With `mode` = 1 (pattern), the unit fires when every synchronized line whose `pat_mask` bit is 1 equals the matching `pat_value` bit. Lines whose mask bit is 0 are ignored, so an all-zero mask matches at once.
- R5: With `mode` = 2 (analog), the unit fires in a cycle where `sample_valid` is high and the unsigned `sample` satisfies `cmp_op` against `threshold`. The encodings are 0 = greater-than, 1 = less-than, 2 = greater-or-equal and 3 = less-or-equal. `start_pulse` follows at the next clock. When `sample_valid` is low, the sample is ignored.
- R6: `start_pulse` is high for exactly one cycle. It appears in the same cycle that `triggered` rises, and only after the unit was armed with its condition met.
- R7: Once fired, `triggered` stays high and no further `start_pulse` is produced, whatever the inputs do, until `clear`.
- R8: `clear` drops `triggered` and `armed` at the next clock. An `arm` pulse while `triggered` is high has no effect.
- R9: `mode` = 3 is reserved. While armed in that mode the unit never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | NLINES | Asynchronous digital lines |
| sample | input | SW | Unsigned analog sample code |
| sample_valid | input | 1 | Sample qualifier |
| mode | input | 2 | Condition select: 0 edge, 1 pattern, 2 analog, 3 reserved |
| edge_sel | input | $clog2(NLINES) | Line watched in edge mode |
| pat_value | input | NLINES | Pattern value |
| pat_mask | input | NLINES | 1 = line takes part in the pattern test |
| threshold | input | SW | Analog threshold |
| cmp_op | input | 2 | Comparison: 0 GT, 1 LT, 2 GE, 3 LE |
| arm | input | 1 | Arm request |
| clear | input | 1 | Disarm and drop the flag |
| armed | output | 1 | Unit is waiting for its condition |
| start_pulse | output | 1 | One-cycle start of the task |
| triggered | output | 1 | Sticky fired flag |

## Verification
The bench uses the defaults: 8 digital lines and 12-bit samples. Eight lines allow a mask that splits the bus in half, so the bench can toggle the ignored upper nibble while the lower nibble decides the match. Twelve-bit codes keep the extremes 0 and 4095 cheap to reach. They also put 2048 against 2047 across the top bit, and that pair fires only if the comparison is truly unsigned. The equal-value vectors separate strict from non-strict operators.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    MODE_EDGE    = 2'd0,
    MODE_PATTERN = 2'd1,
    MODE_ANALOG  = 2'd2,
    MODE_RSVD    = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LT = 2'd1,
    CMP_GE = 2'd2,
    CMP_LE = 2'd3
  } cmp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FIRED = 2'd2
  } ctrl_state_e;

  // Unsigned comparison of a against b under the selected operator.
  function automatic logic cmp_unsigned(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input cmp_op_e     op);
    logic r;
    case (op)
      CMP_GT:  r = (a >  b);
      CMP_LT:  r = (a <  b);
      CMP_GE:  r = (a >= b);
      default: r = (a <= b);
    endcase
    return r;
  endfunction

  // One line of the pattern test: a masked-off line always agrees.
  function automatic logic line_agrees(input logic level,
                                       input logic want,
                                       input logic used);
    return !used || (level == want);
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/trig_cond.sv
module trig_cond
  import trig_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int SW     = 12,
  localparam int SELW  = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] din_s,
  input  logic [SW-1:0]     sample,
  input  logic              sample_valid,
  input  logic [1:0]        mode,
  input  logic [SELW-1:0]   edge_sel,
  input  logic [NLINES-1:0] pat_value,
  input  logic [NLINES-1:0] pat_mask,
  input  logic [SW-1:0]     threshold,
  input  logic [1:0]        cmp_op,
  output logic              cond_hit
);

  logic [NLINES-1:0] din_prev;
  logic [NLINES-1:0] line_ok;
  logic              edge_hit;
  logic              pat_hit;
  logic              ana_hit;

  // Previous synchronized level, kept up to date even while disarmed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_prev <= '0;
    else        din_prev <= din_s;
  end

  assign edge_hit = din_s[edge_sel] && !din_prev[edge_sel];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign line_ok[i] = line_agrees(din_s[i], pat_value[i], pat_mask[i]);
  end

  assign pat_hit = &line_ok;

  assign ana_hit = sample_valid &&
                   cmp_unsigned(32'(sample), 32'(threshold), cmp_op_e'(cmp_op));

  always_comb begin
    case (trig_mode_e'(mode))
      MODE_EDGE:    cond_hit = edge_hit;
      MODE_PATTERN: cond_hit = pat_hit;
      MODE_ANALOG:  cond_hit = ana_hit;
      default:      cond_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic clear,
  input  logic cond_hit,
  output logic armed,
  output logic triggered,
  output logic start_pulse
);

  ctrl_state_e state_q, state_d;
  logic        fire_evt;
  logic        start_q;

  assign fire_evt = (state_q == ST_ARMED) && cond_hit && !clear;

  always_comb begin
    state_d = state_q;
    if (clear) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (arm)      state_d = ST_ARMED;
        ST_ARMED: if (cond_hit) state_d = ST_FIRED;
        default:  state_d = ST_FIRED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= fire_evt;
    end
  end

  assign armed       = (state_q == ST_ARMED);
  assign triggered   = (state_q == ST_FIRED);
  assign start_pulse = start_q;

endmodule

// File: rtl/start_trigger_unit.sv
module start_trigger_unit #(
  parameter int NLINES      = 8,
  parameter int SW          = 12,
  parameter int SYNC_STAGES = 2,
  localparam int SELW       = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] din,
  input  logic [SW-1:0]     sample,
  input  logic              sample_valid,
  input  logic [1:0]        mode,
  input  logic [SELW-1:0]   edge_sel,
  input  logic [NLINES-1:0] pat_value,
  input  logic [NLINES-1:0] pat_mask,
  input  logic [SW-1:0]     threshold,
  input  logic [1:0]        cmp_op,
  input  logic              arm,
  input  logic              clear,
  output logic              armed,
  output logic              start_pulse,
  output logic              triggered
);

  logic [NLINES-1:0] din_s;
  logic              cond_hit;

  trig_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (din),
    .d_sync  (din_s)
  );

  trig_cond #(.NLINES(NLINES), .SW(SW)) u_cond (
    .clk          (clk),
    .rst_n        (rst_n),
    .din_s        (din_s),
    .sample       (sample),
    .sample_valid (sample_valid),
    .mode         (mode),
    .edge_sel     (edge_sel),
    .pat_value    (pat_value),
    .pat_mask     (pat_mask),
    .threshold    (threshold),
    .cmp_op       (cmp_op),
    .cond_hit     (cond_hit)
  );

  trig_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .clear       (clear),
    .cond_hit    (cond_hit),
    .armed       (armed),
    .triggered   (triggered),
    .start_pulse (start_pulse)
  );

endmodule

// File: rtl/trig_checks.sv
module trig_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       arm,
  input logic       clear,
  input logic       sample_valid,
  input logic [1:0] mode,
  input logic       cond_hit,
  input logic       armed,
  input logic       triggered,
  input logic       start_pulse
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !armed && !triggered && !start_pulse); // R1

  AST_ARM_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !triggered && arm && !clear |=> armed); // R2

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R6

  AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $rose(triggered)); // R6

  AST_FIRE_WHEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    armed && cond_hit && !clear |=> start_pulse); // R6

  AST_NO_FIRE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !start_pulse); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    triggered && !clear |=> triggered); // R7

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !armed && !triggered); // R8

  AST_ARM_IGNORED_FIRED: assert property (@(posedge clk) disable iff (!rst_n)
    triggered && !clear |=> !armed); // R8

  AST_ANALOG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    armed && mode == 2'd2 && !sample_valid |=> !start_pulse); // R5

  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    armed && mode == 2'd3 |=> !start_pulse); // R9

endmodule

bind start_trigger_unit trig_checks u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .arm          (arm),
  .clear        (clear),
  .sample_valid (sample_valid),
  .mode         (mode),
  .cond_hit     (cond_hit),
  .armed        (armed),
  .triggered    (triggered),
  .start_pulse  (start_pulse)
);

// File: tb/start_trigger_unit_test.sv
`timescale 1ns/1ps
module start_trigger_unit_test;

  localparam int NLINES = 8;
  localparam int SW     = 12;
  localparam int SELW   = $clog2(NLINES);
  localparam int NVEC   = 11;

  // {cmp_op, sample_valid, expect_fire, sample, threshold}
  localparam logic [27:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 1'b1, 12'd100,  12'd99},
    {2'd0, 1'b1, 1'b0, 12'd99,   12'd99},
    {2'd1, 1'b1, 1'b1, 12'd98,   12'd99},
    {2'd1, 1'b1, 1'b0, 12'd99,   12'd99},
    {2'd2, 1'b1, 1'b1, 12'd99,   12'd99},
    {2'd2, 1'b1, 1'b0, 12'd98,   12'd99},
    {2'd3, 1'b1, 1'b1, 12'd99,   12'd99},
    {2'd3, 1'b1, 1'b0, 12'd100,  12'd99},
    {2'd0, 1'b0, 1'b0, 12'd4095, 12'd0},
    {2'd3, 1'b1, 1'b1, 12'd0,    12'd4095},
    {2'd0, 1'b1, 1'b1, 12'd2048, 12'd2047}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NLINES-1:0] din;
  logic [SW-1:0]     sample;
  logic              sample_valid;
  logic [1:0]        mode;
  logic [SELW-1:0]   edge_sel;
  logic [NLINES-1:0] pat_value;
  logic [NLINES-1:0] pat_mask;
  logic [SW-1:0]     threshold;
  logic [1:0]        cmp_op;
  logic              arm;
  logic              clear;
  logic              armed;
  logic              start_pulse;
  logic              triggered;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  start_trigger_unit #(.NLINES(NLINES), .SW(SW)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .din          (din),
    .sample       (sample),
    .sample_valid (sample_valid),
    .mode         (mode),
    .edge_sel     (edge_sel),
    .pat_value    (pat_value),
    .pat_mask     (pat_mask),
    .threshold    (threshold),
    .cmp_op       (cmp_op),
    .arm          (arm),
    .clear        (clear),
    .armed        (armed),
    .start_pulse  (start_pulse),
    .triggered    (triggered)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_clear();
    clear = 1'b1;
    step();
    clear = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    step();
    arm = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; din = '0; sample = '0; sample_valid = 1'b0;
    mode = 2'd0; edge_sel = '0; pat_value = '0; pat_mask = '0;
    threshold = '0; cmp_op = 2'd0; arm = 1'b0; clear = 1'b0;
    step(3);
    chk("R1 armed in reset", armed, 0);
    chk("R1 triggered in reset", triggered, 0);
    chk("R1 start in reset", start_pulse, 0);
    arm = 1'b1;
    step();
    arm = 1'b0;
    chk("R1 arm ignored in reset", armed, 0);
    rst_n = 1'b1;
    step();

    // Analog comparison vectors
    for (int v = 0; v < NVEC; v++) begin
      do_clear();
      mode = 2'd2;
      cmp_op = VEC[v][27:26];
      threshold = VEC[v][11:0];
      do_arm();
      chk($sformatf("R2 armed vec %0d", v), armed, 1);
      sample = VEC[v][23:12];
      sample_valid = VEC[v][25];
      step();
      chk($sformatf("R5 start vec %0d", v), start_pulse, VEC[v][24]);
      sample_valid = 1'b0;
      step();
      chk($sformatf("R6 pulse ends vec %0d", v), start_pulse, 0);
      chk($sformatf("R7 flag vec %0d", v), triggered, VEC[v][24]);
    end

    // Edge mode on line 3
    do_clear();
    mode = 2'd0; edge_sel = 3'd3; din = '0;
    step(3);
    do_arm();
    din[5] = 1'b1;
    step(4);
    chk("R3 other line ignored", start_pulse | triggered, 0);
    din[3] = 1'b1;
    step();
    chk("R3 no start after 1 clk", start_pulse, 0);
    step();
    chk("R3 no start after 2 clk", start_pulse, 0);
    step();
    chk("R3 start on 3rd clk", start_pulse, 1);
    chk("R6 flag with pulse", triggered, 1);
    step();
    chk("R6 pulse one cycle", start_pulse, 0);

    // Level already high at arm time must not fire
    do_clear();
    do_arm();
    step(4);
    chk("R3 held level no fire", triggered, 0);
    chk("R3 still armed", armed, 1);

    // Pattern mode: lower nibble must equal 5, upper ignored
    do_clear();
    mode = 2'd1; pat_mask = 8'h0F; pat_value = 8'h05; din = 8'hF0;
    step(3);
    do_arm();
    step(3);
    chk("R4 mismatch no fire", triggered, 0);
    din = 8'h04;
    step(3);
    chk("R4 one bit off no fire", triggered, 0);
    din = 8'hA5;
    step(2);
    chk("R4 no start before sync", start_pulse, 0);
    step();
    chk("R4 match fires", start_pulse, 1);

    // Sticky flag, no re-fire, arm ignored while fired
    din = 8'h00;
    step(3);
    din = 8'h55;
    step(3);
    chk("R7 no second pulse", start_pulse, 0);
    chk("R7 flag sticky", triggered, 1);
    do_arm();
    chk("R8 arm ignored when fired", armed, 0);
    chk("R8 flag kept", triggered, 1);
    do_clear();
    chk("R8 clear drops flag", triggered, 0);
    chk("R8 clear leaves idle", armed, 0);

    // Clear has priority over arm
    arm = 1'b1; clear = 1'b1;
    step();
    arm = 1'b0; clear = 1'b0;
    chk("R2 clear beats arm", armed, 0);

    // Reserved mode never fires; then all-zero mask matches at once
    mode = 2'd3; pat_mask = '0; sample_valid = 1'b1; sample = 12'd4095;
    threshold = 12'd0; cmp_op = 2'd0;
    do_arm();
    step(4);
    chk("R9 reserved no fire", start_pulse | triggered, 0);
    chk("R9 stays armed", armed, 1);
    sample_valid = 1'b0;
    mode = 2'd1;
    step();
    chk("R4 zero mask fires", start_pulse, 1);
    step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule